// File: doc/BRIEF.md
# Flat-Access Dispatch Slot Arbiter

This block settles the final contents of a row of dispatch slots, one slot per execution unit, in the cycle before instructions leave the scheduler for execution. Each cycle it takes the candidates chosen by an earlier selection step and resolves three things in a fixed order. First it settles the one structural conflict between the pipes. A flat memory instruction sitting in the global-memory slot needs the local-memory path too, so it takes that slot over. Second, every instruction still headed for execution must obtain destination write scheduling from the register files. Third, the execution units claimed by the surviving instructions are checked for double booking.

Instructions that lose are handed back through a reinsertion port so the schedule queue can retry them later. There are two ways to lose: a local-memory instruction pushed aside by a flat access, or any instruction refused a write slot. A refused flat instruction also frees the local slot it had claimed. Register files and memory pipes are outside the block; their grants arrive as plain inputs. Saturating counters record arbitration stalls and write denials, and a sticky error flag reports reservation clashes and inconsistent slot pairings.

Top module: `flat_dispatch_arb`

## Requirements
- R1: While and right after reset, every slot state and slot wave field reads 0, no reinsert is flagged, all four counters read 0 and `err_sticky` is 0.
- R2: Slot states are rebuilt each cycle from that cycle's inputs only. Slot i's state sits at `slot_state[2i+1:2i]`, coded EMPTY=0, EXREADY=1, SKIP=2. A slot with no candidate reads EMPTY with wave 0 one cycle later. A candidate that passes every check reads EXREADY with its own wave ID (`slot_wave[W*i +: W]`).
- R3: A flat access is one where `cand_flat` is 1 and the global slot (index `GM_SLOT`) holds a candidate. If the local slot (index `LM_SLOT`) also holds a candidate, that candidate is reinserted with its own wave ID, and `arb_stall_cnt` rises by one.
- R4: A flat access that passes its write check leaves the local slot in SKIP, carrying the flat instruction's wave ID. No slot other than `LM_SLOT` is ever SKIP.
- R5: Displacement of the local candidate by a flat access happens even when the flat instruction is then refused its write slot.
- R6: An EXREADY candidate needs `srf_wr_ok[i]`. If `cand_scalar[i]` is 0, it also needs `vrf_wr_ok[i]`. On refusal the slot reads EMPTY and the candidate is reinserted with its wave ID.
- R7: When a flat instruction is refused its write slot, the local slot it had claimed also reads EMPTY.
- R8: Each cycle, `vrf_deny_cnt` adds the number of slots refused for a missing vector grant, `srf_deny_cnt` adds those refused for a missing scalar grant, and `any_deny_cnt` adds those refused for either. All counters saturate at 2^CW-1.
- R9: If two EXREADY slots claim the same execution unit in one cycle (mask at `cand_units[U*i +: U]`), `err_sticky` rises one cycle later and holds until reset.
- R10: Whenever the local slot reads SKIP, the global slot reads EXREADY with the same wave ID. A breach sets `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_vld | input | N | Slot holds a candidate this cycle |
| cand_flat | input | 1 | Global-slot candidate is a flat access |
| cand_scalar | input | N | Candidate is a scalar instruction |
| cand_wave | input | N*W | Candidate wave IDs |
| cand_units | input | N*U | Execution units each candidate reserves |
| vrf_wr_ok | input | N | Vector register file grants write scheduling |
| srf_wr_ok | input | N | Scalar register file grants write scheduling |
| slot_state | output | 2*N | Registered slot states |
| slot_wave | output | N*W | Registered wave ID per slot |
| reins_vld | output | N | Slot's candidate handed back for reinsertion |
| reins_wave | output | N*W | Wave ID of each reinserted candidate |
| arb_stall_cnt | output | CW | Local candidates displaced by flat accesses |
| vrf_deny_cnt | output | CW | Write refusals from the vector file |
| srf_deny_cnt | output | CW | Write refusals from the scalar file |
| any_deny_cnt | output | CW | Write refusals of any cause |
| err_sticky | output | 1 | Sticky reservation or pairing error |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This covers slot states, wave fields, reinsert flags, counter increments and the error flag, because all of them pass through a single register stage. The bench drives inputs just after a rising edge and samples one time unit after the next rising edge, so each comparison sees precisely the response to the preceding stimulus. The counter model accumulates from the same per-cycle expectations, so a counter fault shows at the first edge it occurs. The sticky flag is sampled on the edge after the clash and again one cycle later with idle inputs.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
   typedef enum logic [1:0] {
      SLOT_EMPTY   = 2'd0,
      SLOT_EXREADY = 2'd1,
      SLOT_SKIP    = 2'd2
   } slot_st_e;
endpackage

// File: rtl/flat_pair_arb.sv
module flat_pair_arb
   import slot_arb_pkg::*;
#(
   parameter int N       = 4,
   parameter int W       = 4,
   parameter int GM_SLOT = 2,
   parameter int LM_SLOT = 3
) (
   input  logic [N-1:0]          cand_vld,
   input  logic                  cand_flat,
   input  logic [N*W-1:0]        cand_wave,
   output slot_st_e [N-1:0]      st1,
   output logic [N-1:0][W-1:0]   wave1,
   output logic                  flat_go,
   output logic                  displaced
);
   always_comb begin
      for (int i = 0; i < N; i++) begin
         st1[i]   = cand_vld[i] ? SLOT_EXREADY : SLOT_EMPTY;
         wave1[i] = cand_vld[i] ? cand_wave[W*i +: W] : '0;
      end
      flat_go   = cand_vld[GM_SLOT] & cand_flat;
      displaced = flat_go & cand_vld[LM_SLOT];
      if (flat_go) begin
         st1[LM_SLOT]   = SLOT_SKIP;
         wave1[LM_SLOT] = cand_wave[W*GM_SLOT +: W];
      end
   end
endmodule

// File: rtl/wr_grant_chk.sv
module wr_grant_chk
   import slot_arb_pkg::*;
#(
   parameter int N       = 4,
   parameter int GM_SLOT = 2,
   parameter int LM_SLOT = 3
) (
   input  slot_st_e [N-1:0] st1,
   input  logic             flat_go,
   input  logic [N-1:0]     cand_scalar,
   input  logic [N-1:0]     vrf_wr_ok,
   input  logic [N-1:0]     srf_wr_ok,
   output slot_st_e [N-1:0] st2,
   output logic [N-1:0]     deny,
   output logic [N-1:0]     vden,
   output logic [N-1:0]     sden
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      logic chk;
      assign chk     = (st1[i] == SLOT_EXREADY);
      assign sden[i] = chk & ~srf_wr_ok[i];
      assign vden[i] = chk & ~cand_scalar[i] & ~vrf_wr_ok[i];
      assign deny[i] = sden[i] | vden[i];
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         st2[i] = deny[i] ? SLOT_EMPTY : st1[i];
      if (flat_go && deny[GM_SLOT])
         st2[LM_SLOT] = SLOT_EMPTY;
   end
endmodule

// File: rtl/unit_resv.sv
module unit_resv
   import slot_arb_pkg::*;
#(
   parameter int N = 4,
   parameter int U = 4
) (
   input  slot_st_e [N-1:0] st2,
   input  logic [N*U-1:0]   cand_units,
   output logic             clash
);
   logic [U-1:0] taken;
   always_comb begin
      taken = '0;
      clash = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (st2[i] == SLOT_EXREADY) begin
            clash = clash | (|(taken & cand_units[U*i +: U]));
            taken = taken | cand_units[U*i +: U];
         end
      end
   end
endmodule

// File: rtl/flat_dispatch_arb.sv
module flat_dispatch_arb
   import slot_arb_pkg::*;
#(
   parameter int N        = 4,
   parameter int W        = 4,
   parameter int U        = 4,
   parameter int CW       = 8,
   parameter int GM_SLOT  = 2,
   parameter int LM_SLOT  = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   cand_vld,
   input  logic           cand_flat,
   input  logic [N-1:0]   cand_scalar,
   input  logic [N*W-1:0] cand_wave,
   input  logic [N*U-1:0] cand_units,
   input  logic [N-1:0]   vrf_wr_ok,
   input  logic [N-1:0]   srf_wr_ok,
   output logic [2*N-1:0] slot_state,
   output logic [N*W-1:0] slot_wave,
   output logic [N-1:0]   reins_vld,
   output logic [N*W-1:0] reins_wave,
   output logic [CW-1:0]  arb_stall_cnt,
   output logic [CW-1:0]  vrf_deny_cnt,
   output logic [CW-1:0]  srf_deny_cnt,
   output logic [CW-1:0]  any_deny_cnt,
   output logic           err_sticky
);
   localparam int CIW = $clog2(N + 1);
   localparam int NC  = 4;

   if (GM_SLOT == LM_SLOT) begin : g_bad_pair
      $error("global and local slot indices must differ");
   end
   if (GM_SLOT >= N || LM_SLOT >= N) begin : g_bad_idx
      $error("slot index out of range");
   end
   if (CW < CIW) begin : g_bad_cw
      $error("counter width too small for per-cycle increment");
   end

   slot_st_e [N-1:0]    st1, st2;
   logic [N-1:0][W-1:0] wave1;
   logic                flat_go, displaced;
   logic [N-1:0]        deny, vden, sden;
   logic                clash, pair_bad;

   flat_pair_arb #(.N(N), .W(W), .GM_SLOT(GM_SLOT), .LM_SLOT(LM_SLOT)) u_pair (
      .cand_vld(cand_vld), .cand_flat(cand_flat), .cand_wave(cand_wave),
      .st1(st1), .wave1(wave1), .flat_go(flat_go), .displaced(displaced));

   wr_grant_chk #(.N(N), .GM_SLOT(GM_SLOT), .LM_SLOT(LM_SLOT)) u_wr (
      .st1(st1), .flat_go(flat_go), .cand_scalar(cand_scalar),
      .vrf_wr_ok(vrf_wr_ok), .srf_wr_ok(srf_wr_ok),
      .st2(st2), .deny(deny), .vden(vden), .sden(sden));

   unit_resv #(.N(N), .U(U)) u_resv (
      .st2(st2), .cand_units(cand_units), .clash(clash));

   assign pair_bad = (st2[LM_SLOT] == SLOT_SKIP) &&
                     ((st2[GM_SLOT] != SLOT_EXREADY) || (wave1[LM_SLOT] != wave1[GM_SLOT]));

   // next-cycle slot contents
   logic [2*N-1:0] state_d;
   logic [N*W-1:0] wave_d, rwave_d;
   logic [N-1:0]   rvld_d;
   always_comb begin
      for (int i = 0; i < N; i++) begin
         state_d[2*i +: 2] = st2[i];
         wave_d[W*i +: W]  = (st2[i] == SLOT_EMPTY) ? '0 : wave1[i];
         rvld_d[i]         = deny[i] | ((i == LM_SLOT) & displaced);
         rwave_d[W*i +: W] = rvld_d[i] ? cand_wave[W*i +: W] : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_state <= '0;
         slot_wave  <= '0;
         reins_vld  <= '0;
         reins_wave <= '0;
         err_sticky <= 1'b0;
      end else begin
         slot_state <= state_d;
         slot_wave  <= wave_d;
         reins_vld  <= rvld_d;
         reins_wave <= rwave_d;
         err_sticky <= err_sticky | clash | pair_bad;
      end
   end

   // event counters: 0 arb, 1 vector deny, 2 scalar deny, 3 any deny
   logic [NC-1:0][CIW-1:0] inc;
   always_comb begin
      inc = '0;
      inc[0] = CIW'(displaced);
      for (int i = 0; i < N; i++) begin
         inc[1] = inc[1] + CIW'(vden[i]);
         inc[2] = inc[2] + CIW'(sden[i]);
         inc[3] = inc[3] + CIW'(deny[i]);
      end
   end

   logic [NC-1:0][CW-1:0] cnt_q;
   for (genvar c = 0; c < NC; c++) begin : g_cnt
      logic [CW:0]   sum;
      logic [CW-1:0] nxt;
      assign sum = {1'b0, cnt_q[c]} + (CW+1)'(inc[c]);
      if (SATURATE) begin : g_sat
         assign nxt = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
      end else begin : g_wrap
         assign nxt = sum[CW-1:0];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q[c] <= '0;
         else        cnt_q[c] <= nxt;
      end
   end

   assign arb_stall_cnt = cnt_q[0];
   assign vrf_deny_cnt  = cnt_q[1];
   assign srf_deny_cnt  = cnt_q[2];
   assign any_deny_cnt  = cnt_q[3];
endmodule

// File: rtl/flat_dispatch_arb_chk.sv
module flat_dispatch_arb_chk #(
   parameter int N       = 4,
   parameter int W       = 4,
   parameter int CW      = 8,
   parameter int GM_SLOT = 2,
   parameter int LM_SLOT = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic [2*N-1:0] slot_state,
   input logic [N*W-1:0] slot_wave,
   input logic [N-1:0]   reins_vld,
   input logic [CW-1:0]  any_deny_cnt,
   input logic           err_sticky
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
         slot_state[2*i +: 2] != 2'd3);
      a_r6_reins_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
         reins_vld[i] |-> slot_state[2*i +: 2] != 2'd1);
      if (i != LM_SLOT) begin : g_nolm
         a_r4_skip_only_local: assert property (@(posedge clk) disable iff (!rst_n)
            slot_state[2*i +: 2] != 2'd2);
      end
   end

   a_r10_skip_pair: assert property (@(posedge clk) disable iff (!rst_n)
      slot_state[2*LM_SLOT +: 2] == 2'd2 |->
         (slot_state[2*GM_SLOT +: 2] == 2'd1 &&
          slot_wave[W*LM_SLOT +: W] == slot_wave[W*GM_SLOT +: W]));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   a_r8_any_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> any_deny_cnt >= $past(any_deny_cnt));
endmodule

bind flat_dispatch_arb flat_dispatch_arb_chk #(
   .N(N), .W(W), .CW(CW), .GM_SLOT(GM_SLOT), .LM_SLOT(LM_SLOT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_state(slot_state), .slot_wave(slot_wave),
   .reins_vld(reins_vld), .any_deny_cnt(any_deny_cnt), .err_sticky(err_sticky)
);

// File: tb/flat_dispatch_arb_tb_top.sv
module flat_dispatch_arb_tb_top;
   localparam int N = 4, W = 4, U = 4, CW = 8, GM = 2, LM = 3;
   localparam int CMAX = (1 << CW) - 1;
   localparam time CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic [N-1:0]   cand_vld, cand_scalar, vrf_wr_ok, srf_wr_ok;
   logic           cand_flat;
   logic [N*W-1:0] cand_wave;
   logic [N*U-1:0] cand_units;
   logic [2*N-1:0] slot_state;
   logic [N*W-1:0] slot_wave, reins_wave;
   logic [N-1:0]   reins_vld;
   logic [CW-1:0]  arb_stall_cnt, vrf_deny_cnt, srf_deny_cnt, any_deny_cnt;
   logic           err_sticky;

   int checks = 0, errors = 0;
   int m_arb = 0, m_vd = 0, m_sd = 0, m_any = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flat_dispatch_arb #(.N(N), .W(W), .U(U), .CW(CW), .GM_SLOT(GM), .LM_SLOT(LM)) dut_i (
      .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_flat(cand_flat),
      .cand_scalar(cand_scalar), .cand_wave(cand_wave), .cand_units(cand_units),
      .vrf_wr_ok(vrf_wr_ok), .srf_wr_ok(srf_wr_ok), .slot_state(slot_state),
      .slot_wave(slot_wave), .reins_vld(reins_vld), .reins_wave(reins_wave),
      .arb_stall_cnt(arb_stall_cnt), .vrf_deny_cnt(vrf_deny_cnt),
      .srf_deny_cnt(srf_deny_cnt), .any_deny_cnt(any_deny_cnt), .err_sticky(err_sticky));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   task automatic idle();
      cand_vld = '0; cand_flat = 0; cand_scalar = '0; cand_wave = '0;
      cand_units = '0; vrf_wr_ok = '1; srf_wr_ok = '1;
   endtask

   task automatic check_reset(input string tag);
      chk({tag, " R1 state"}, slot_state, 0);
      chk({tag, " R1 wave"}, slot_wave, 0);
      chk({tag, " R1 reins"}, reins_vld, 0);
      chk({tag, " R1 cnt"}, {arb_stall_cnt, vrf_deny_cnt, srf_deny_cnt, any_deny_cnt}, 0);
      chk({tag, " R1 err"}, err_sticky, 0);
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      repeat (3) step();
      check_reset("in reset");
      rst_n = 1;
      m_arb = 0; m_vd = 0; m_sd = 0; m_any = 0;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      do_reset();
      step();
      check_reset("after reset");

      // sweep: candidates x flat x vector grants x scalar grants
      for (int v = 0; v < 16; v++)
         for (int f = 0; f < 2; f++)
            for (int vo = 0; vo < 16; vo++)
               for (int so = 0; so < 16; so++) begin
                  logic [3:0] vv, vg, sg, sc;
                  logic [1:0] es [N];
                  logic [W-1:0] wv [N];
                  logic [W-1:0] ew [N];
                  logic [N-1:0] er;
                  logic [2*N-1:0] est;
                  logic [N*W-1:0] eww, erw;
                  bit flat, disp;
                  int nv, ns, na;
                  vv = 4'(v); vg = 4'(vo); sg = 4'(so);
                  sc = vv ^ {sg[0], vg[3:1]};
                  for (int i = 0; i < N; i++) wv[i] = W'((i*5 + v + f + 1) % 16);
                  cand_vld = vv; cand_flat = f[0]; cand_scalar = sc;
                  vrf_wr_ok = vg; srf_wr_ok = sg;
                  for (int i = 0; i < N; i++) cand_wave[W*i +: W] = wv[i];
                  cand_units = '0;
                  for (int i = 0; i < N; i++) cand_units[U*i + i] = 1'b1;
                  if (f != 0) cand_units[U*GM + LM] = 1'b1;
                  // expected response
                  er = '0; nv = 0; ns = 0; na = 0;
                  for (int i = 0; i < N; i++) begin
                     es[i] = vv[i] ? 2'd1 : 2'd0;
                     ew[i] = wv[i];
                  end
                  flat = vv[GM] && (f != 0);
                  disp = flat && vv[LM];
                  if (flat) begin es[LM] = 2'd2; ew[LM] = wv[GM]; end
                  for (int i = 0; i < N; i++)
                     if (es[i] == 2'd1) begin
                        bit vb, sb;
                        sb = !sg[i];
                        vb = !sc[i] && !vg[i];
                        if (sb) ns++;
                        if (vb) nv++;
                        if (sb || vb) begin na++; es[i] = 2'd0; er[i] = 1'b1; end
                     end
                  if (flat && es[GM] == 2'd0) es[LM] = 2'd0;
                  if (disp) er[LM] = 1'b1;
                  m_arb = sat(m_arb + (disp ? 1 : 0));
                  m_vd = sat(m_vd + nv); m_sd = sat(m_sd + ns); m_any = sat(m_any + na);
                  est = '0; eww = '0; erw = '0;
                  for (int i = 0; i < N; i++) begin
                     est[2*i +: 2] = es[i];
                     if (es[i] != 2'd0) eww[W*i +: W] = ew[i];
                     if (er[i]) erw[W*i +: W] = wv[i];
                  end
                  step();
                  chk(flat ? "R3 R4 R5 R7 R10 state" : "R2 R6 state", slot_state, est);
                  chk(flat ? "R4 R10 skip wave" : "R2 wave", slot_wave, eww);
                  chk(disp ? "R3 R5 reinsert" : "R6 reinsert", reins_vld, er);
                  chk("R3 R6 reinsert wave", reins_wave, erw);
                  chk("R3 arb counter", arb_stall_cnt, m_arb);
                  chk("R8 vector deny counter", vrf_deny_cnt, m_vd);
                  chk("R8 scalar deny counter", srf_deny_cnt, m_sd);
                  chk("R8 any deny counter", any_deny_cnt, m_any);
                  chk("R9 err clean", err_sticky, 0);
               end

      // R9: two ready slots claim unit 0
      idle();
      cand_vld = 4'b0011;
      cand_units[0] = 1'b1; cand_units[U] = 1'b1;
      step();
      chk("R9 clash state", slot_state, 8'b0000_0101);
      chk("R9 err set", err_sticky, 1);
      idle();
      step();
      chk("R9 err held", err_sticky, 1);
      chk("R2 idle empty", slot_state, 0);
      do_reset();
      step();
      check_reset("R9 cleared by reset");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule